// File: doc/BRIEF.md
# Repeated-Addition Sequential Multiplier

This block forms the product of two unsigned operands with one adder and a down-counter instead of a shift-add array. On an accepted start it captures the first operand into a counter and the second into an addend register, and it clears a double-width product accumulator. After that, each clock adds the addend into the accumulator and takes one from the counter. This goes on until the counter reads zero. The block then returns to idle and raises a completion pulse for one cycle.

Latency depends on the value of the first operand, not on its width. A caller that knows its first operand is usually small can take advantage of that. The product output always shows the accumulator. It holds the last result until the next accepted start. While a job is running the block accepts no new start.

Top module: `addmul_top`

## Requirements
- R1: After reset, prod_o is 0, zero_o is 1 and done_o is 0.
- R2: A start_i high on a clock edge while idle captures opa_i and opb_i and clears the accumulator. After that edge prod_o is 0 and zero_o is 1 exactly when opa_i was 0.
- R3: While running with the counter non-zero, every clock edge raises prod_o by the captured opb_i value and lowers the counter by one.
- R4: done_o goes high for exactly one cycle, after the (A+1)-th rising edge that follows the edge that accepted start, where A is the captured opa_i. prod_o then equals A*B.
- R5: With opa_i equal to 0 the result is 0, and done_o follows one edge after the accepting edge.
- R6: With opb_i equal to 0 the result is 0, and it still takes A counting cycles.
- R7: A start_i pulse while a job is running has no effect: the running job's result and latency are unchanged, and no extra done_o pulse occurs.
- R8: While idle with start_i low, prod_o holds its value.
- R9: The counter never wraps below zero. Once zero_o is 1 it stays 1 until a start is accepted.
- R10: The product register is 2*OPW bits wide, so maximum operands produce the full product without overflow (255*255 = 65025 at the default width).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a multiplication (taken only when idle) |
| opa_i | input | OPW | Operand that sets the iteration count |
| opb_i | input | OPW | Operand added once per iteration |
| prod_o | output | 2*OPW | Product accumulator |
| zero_o | output | 1 | High when the iteration counter is zero |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the cycle-level rules on every edge. They confirm that an accepted start clears the accumulator, that each running cycle adds the addend and takes exactly one from the counter, that the accumulator is frozen while idle, that the counter cannot leave zero without a load, that a running job cannot be pushed back to idle before the counter reaches zero, and that the completion pulse lasts one cycle. Only the bench scenarios show the end-to-end results. These are the exact product against A*B, the latency of A+1 edges, the behaviour at the operand corners (zero operands, maximum operands) and the lack of any effect from a start pulse in the middle of a job.

// File: rtl/addmul_pkg.sv
package addmul_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } addmul_state_e;

   // Adder variants for the accumulator
   localparam int ADD_FLAT  = 0;
   localparam int ADD_SPLIT = 1;

endpackage

// File: rtl/addmul_ctrl.sv
module addmul_ctrl
   import addmul_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic cnt_zero_i,
   output logic load_o,
   output logic step_o,
   output logic busy_o,
   output logic done_o
);

   addmul_state_e state_q, state_d;
   logic          done_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start_i)    state_d = ST_RUN;
         ST_RUN:  if (cnt_zero_i) state_d = ST_IDLE;
         default:                 state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= (state_q == ST_RUN) && cnt_zero_i;
      end
   end

   assign load_o = (state_q == ST_IDLE) && start_i;
   assign step_o = (state_q == ST_RUN) && !cnt_zero_i;
   assign busy_o = (state_q == ST_RUN);
   assign done_o = done_q;

   // R4: completion lasts a single cycle
   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7: a running job with work left stays running whatever start does
   p_run_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !cnt_zero_i) |=> busy_o);

   // R4: completion follows a run that saw the counter at zero
   p_done_after_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cnt_zero_i) |=> (done_o && !busy_o));

endmodule

// File: rtl/addmul_cnt.sv
module addmul_cnt #(
   parameter int OPW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_i,
   input  logic           step_i,
   input  logic [OPW-1:0] a_i,
   output logic           zero_o
);

   localparam logic [OPW-1:0] ONE = OPW'(1);

   logic [OPW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= a_i;
      else if (step_i && (cnt_q != '0))
         cnt_q <= cnt_q - ONE;
   end

   assign zero_o = (cnt_q == '0);

   // R9: zero is sticky until a load
   p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_o && !load_i) |=> zero_o);

   // R3: one step lowers the count by exactly one
   p_dec_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/addmul_acc.sv
module addmul_acc
   import addmul_pkg::*;
#(
   parameter int OPW       = 8,
   parameter int ADD_STYLE = ADD_FLAT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   input  logic [OPW-1:0]   b_i,
   output logic [2*OPW-1:0] prod_o
);

   localparam int PW = 2 * OPW;
   localparam int HW = PW / 2;

   logic [OPW-1:0] breg_q;
   logic [PW-1:0]  prod_q;
   logic [PW-1:0]  sum;
   logic [PW-1:0]  addend;

   assign addend = {{(PW-OPW){1'b0}}, breg_q};

   generate
      if (ADD_STYLE == ADD_SPLIT) begin : g_split
         logic [HW:0]    lo_sum;
         logic [PW-HW-1:0] hi_sum;
         assign lo_sum = {1'b0, prod_q[HW-1:0]} + {1'b0, addend[HW-1:0]};
         assign hi_sum = prod_q[PW-1:HW] + addend[PW-1:HW]
                       + {{(PW-HW-1){1'b0}}, lo_sum[HW]};
         assign sum    = {hi_sum, lo_sum[HW-1:0]};
      end else begin : g_flat
         assign sum = prod_q + addend;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         breg_q <= '0;
         prod_q <= '0;
      end else if (load_i) begin
         breg_q <= b_i;
         prod_q <= '0;
      end else if (step_i) begin
         prod_q <= sum;
      end
   end

   assign prod_o = prod_q;

   // R2: an accepted start clears the accumulator
   p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (prod_o == '0));

   // R3: each step adds the captured addend
   p_add_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (prod_o == $past(prod_o) + {{(PW-OPW){1'b0}}, $past(breg_q)}));

   // R8: no load and no step leaves the product untouched
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !step_i) |=> $stable(prod_o));

endmodule

// File: rtl/addmul_top.sv
module addmul_top
   import addmul_pkg::*;
#(
   parameter int OPW       = 8,
   parameter int ADD_STYLE = ADD_FLAT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [OPW-1:0]   opa_i,
   input  logic [OPW-1:0]   opb_i,
   output logic [2*OPW-1:0] prod_o,
   output logic             zero_o,
   output logic             done_o
);

   generate
      if (OPW < 1) begin : g_bad_width
         initial $fatal(1, "addmul_top: OPW must be at least 1");
      end
      if (ADD_STYLE != ADD_FLAT && ADD_STYLE != ADD_SPLIT) begin : g_bad_style
         initial $fatal(1, "addmul_top: unknown ADD_STYLE");
      end
   endgenerate

   logic load, step, busy, cnt_zero;

   addmul_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .cnt_zero_i (cnt_zero),
      .load_o     (load),
      .step_o     (step),
      .busy_o     (busy),
      .done_o     (done_o)
   );

   addmul_cnt #(.OPW(OPW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .step_i (step),
      .a_i    (opa_i),
      .zero_o (cnt_zero)
   );

   addmul_acc #(.OPW(OPW), .ADD_STYLE(ADD_STYLE)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .step_i (step),
      .b_i    (opb_i),
      .prod_o (prod_o)
   );

   assign zero_o = cnt_zero;

   // R7: a start seen while running does not restart the accumulator
   p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i && !cnt_zero) |=> (prod_o != '0 || $past(prod_o) == '0));

endmodule

// File: tb/sim_addmul_top.sv
module sim_addmul_top;

   localparam int CLK_PERIOD = 10;
   localparam int OPW        = 8;
   localparam int PW         = 2 * OPW;
   localparam int WATCHDOG   = 100000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start_i = 1'b0;
   logic [OPW-1:0] opa_i = '0;
   logic [OPW-1:0] opb_i = '0;
   logic [PW-1:0]  prod_o;
   logic           zero_o;
   logic           done_o;

   int checks = 0;
   int errors = 0;
   int edgecnt = 0;
   bit finished = 0;

   typedef struct {
      logic [PW-1:0] prod;
      int            a;
      int            edge0;
   } item_t;

   item_t exp_q[$];

   addmul_top #(.OPW(OPW)) u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .opa_i   (opa_i),
      .opb_i   (opb_i),
      .prod_o  (prod_o),
      .zero_o  (zero_o),
      .done_o  (done_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) edgecnt <= edgecnt + 1;

   task automatic chk(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Driver: launch one job and push its expectation
   task automatic launch(int a, int b);
      item_t it;
      wait (exp_q.size() == 0);
      @(negedge clk);
      opa_i   = OPW'(a);
      opb_i   = OPW'(b);
      start_i = 1'b1;
      it.prod  = PW'(a * b);
      it.a     = a;
      it.edge0 = edgecnt + 1;
      exp_q.push_back(it);
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // Monitor: compare each completion with the scoreboard
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (exp_q.size() == 0) begin
            chk("R7 unexpected done", 1, 0);
         end else begin
            item_t it;
            it = exp_q.pop_front();
            chk("R4 product", prod_o, it.prod);
            chk("R4 latency", edgecnt - it.edge0, it.a + 1);
         end
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 prod", prod_o, 0);
      chk("R1 zero", zero_o, 1);
      chk("R1 done", done_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 and R3: start clears, then B is added each cycle
      launch(3, 5);
      chk("R2 cleared", prod_o, 0);
      chk("R2 zero low", zero_o, 0);
      for (int i = 1; i <= 3; i++) begin
         @(negedge clk);
         chk("R3 step", prod_o, 5 * i);
      end
      wait (exp_q.size() == 0);
      @(negedge clk);
      chk("R4 done single", done_o, 0);
      chk("R9 zero after", zero_o, 1);

      // R5 A zero
      launch(0, 77);
      chk("R2 zero high on A=0", zero_o, 1);
      wait (exp_q.size() == 0);
      chk("R5 result", prod_o, 0);

      // R6 B zero
      launch(6, 0);
      wait (exp_q.size() == 0);
      chk("R6 result", prod_o, 0);

      // R7 start while running
      launch(4, 3);
      @(negedge clk);
      opa_i = 8'd9; opb_i = 8'd9; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R7 not restarted", prod_o, 6);
      wait (exp_q.size() == 0);
      chk("R7 result kept", prod_o, 12);

      // R8 and R9: idle hold
      opa_i = 8'd200; opb_i = 8'd200;
      repeat (5) @(negedge clk);
      chk("R8 hold", prod_o, 12);
      chk("R9 zero sticky", zero_o, 1);
      chk("R7 no extra done", done_o, 0);

      // R10 maximum operands and a few more patterns
      launch(255, 255);
      launch(1, 200);
      launch(17, 13);
      launch(2, 128);
      wait (exp_q.size() == 0);
      repeat (3) @(negedge clk);
      chk("R10 final", prod_o, 256);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule